// File: doc/BRIEF.md
# Memory ECC Error Manager

This block sits beside a memory ECC checker and turns its per-read error events into software-visible state. Every event arrives as a one-cycle pulse tagged with its kind (correctable single-bit, uncorrectable multi-bit, or a bad memory select) and carries the failing address, the 64 read data bits, the 8 check bits and the transaction attributes. The block keeps sticky detect flags, a programmable single-bit error counter with a threshold, per-kind disable and interrupt-enable controls, and a set of capture registers that hold the details of the first accepted error.

Single-bit errors are absorbed quietly until the counter reaches the threshold. The counter then restarts from zero and the single-bit flag is raised. If the threshold is reached again while that flag is still up, a separate flag records that more than one error has been lost to the summary. Software reads and writes all state through a word-addressed port with byte strobes. A single level interrupt summarises the enabled flags.

Top module: `mem_err_mgr`

## Requirements
- R1: After reset all detect flags, disable bits, interrupt enables, the counter and every capture word read as zero. The threshold field reads as the parameter SBE_THR_INIT (255 by default), and irq is low.
- R2: Register word addresses are 0 status, 1 disable, 2 interrupt enable, 3 single-bit management, 4 capture address, 5 capture data high (bits 63:32), 6 capture data low, 7 capture check bits, and 8 capture attributes. Unmapped addresses read zero. Writes apply only the byte lanes selected by reg_wstrb. The management word holds the counter in bits 7:0 and the threshold in bits 23:16, so a write with only strobe 0 or only strobe 2 changes one field and leaves the other intact.
- R3: The event kind codes are 0 single-bit, 1 multi-bit, 2 memory-select and 3 no effect. Each accepted single-bit event increments the counter. When the incremented value equals a nonzero threshold, the counter becomes zero and status bit 0 is set.
- R4: If the threshold is reached while status bit 0 is already set, status bit 3 (repeat errors) is set too.
- R5: With a threshold of zero, every accepted single-bit event sets status bit 0 and leaves the counter at zero.
- R6: An accepted multi-bit event sets status bit 1 in the cycle after its pulse, and also sets bit 3 if bit 1 was already set. An accepted memory-select event sets status bit 2 and never sets bit 3.
- R7: Status bits are sticky and are cleared by writing 1 to them. A flag that hardware sets in the same cycle as a clearing write ends up set.
- R8: Disable bits 0, 1 and 2 (single-bit, multi-bit, memory-select) make events of that kind fully ignored: no flag, no count and no capture.
- R9: irq is high exactly while some status bit 0..2 is set with the matching enable bit (same positions) set. It follows an event one cycle after the pulse and stays high until the flag or the enable is cleared.
- R10: An accepted event while attribute bit 0 (valid) is clear loads the address, the data halves, the check bits and the attributes, and sets valid. The attribute layout is beat in bits 6:4, size in bits 10:8, source in bits 20:16 and type in bits 25:24. While valid is set, later events leave all capture words unchanged.
- R11: Capture words are writable. Writing zero clears a word, and clearing the attribute word re-arms capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | One-cycle error event pulse |
| evt_type | input | 2 | Event kind: 0 single-bit, 1 multi-bit, 2 memory-select, 3 none |
| evt_addr | input | ERR_AW | Failing address |
| evt_data | input | DATA_W | Read data of the failing beat |
| evt_ecc | input | ECC_W | Check bits of the failing beat |
| evt_beat | input | BEAT_W | Beat number within the burst |
| evt_tsiz | input | TSIZ_W | Transaction size |
| evt_tsrc | input | TSRC_W | Transaction source |
| evt_ttyp | input | TTYP_W | Transaction type |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word address |
| reg_wdata | input | REG_DW | Write data |
| reg_wstrb | input | REG_DW/8 | Byte-lane write enables |
| reg_rdata | output | REG_DW | Read data for reg_addr (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
Most internal faults in this block surface at the ports on the very next cycle. A wrong counter increment or threshold compare makes the management word read one count off after the first event, or makes status bit 0 rise at the wrong event of a run. A flag that fails to stick, or one that is set by a disabled kind, shows in the status read and in irq one cycle after the pulse. A capture lock that is missing appears as a changed capture address after the second accepted event. A repeat-errors flag raised by the wrong kind only becomes visible once that kind has occurred twice, so the sequences repeat every kind at least twice.

// File: rtl/mem_err_pkg.sv
package mem_err_pkg;

   typedef enum logic [1:0] {
      EV_SINGLE = 2'd0,
      EV_MULTI  = 2'd1,
      EV_MSEL   = 2'd2,
      EV_NONE   = 2'd3
   } ev_kind_e;

   // status bit positions
   localparam int FLG_SBE   = 0;
   localparam int FLG_MBE   = 1;
   localparam int FLG_MSE   = 2;
   localparam int FLG_MULTI = 3;
   localparam int NFLAG     = 4;
   localparam int NKIND     = 3;

   // register word indices
   localparam int RA_STATUS = 0;
   localparam int RA_DIS    = 1;
   localparam int RA_IEN    = 2;
   localparam int RA_SBE    = 3;
   localparam int RA_CADDR  = 4;
   localparam int RA_CDHI   = 5;
   localparam int RA_CDLO   = 6;
   localparam int RA_CECC   = 7;
   localparam int RA_CATTR  = 8;
   localparam int NREG      = 9;
   localparam int NCAP      = 5;

   // management word field offsets
   localparam int SBE_CNT_LSB = 0;
   localparam int SBE_THR_LSB = 16;

   // attribute word field offsets
   localparam int AT_VLD  = 0;
   localparam int AT_BEAT = 4;
   localparam int AT_TSIZ = 8;
   localparam int AT_TSRC = 16;
   localparam int AT_TTYP = 24;

   function automatic logic [31:0] field_mask(input int width, input int lsb);
      logic [63:0] ones;
      ones = (64'h1 << width) - 64'h1;
      return 32'(ones << lsb);
   endfunction

endpackage

// File: rtl/mem_err_sbe_ctr.sv
module mem_err_sbe_ctr #(
   parameter int CNT_W    = 8,
   parameter int THR_INIT = 255
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             cnt_we_i,
   input  logic [CNT_W-1:0] cnt_wd_i,
   input  logic             thr_we_i,
   input  logic [CNT_W-1:0] thr_wd_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] thr_o,
   output logic             hit_o
);
   logic [CNT_W-1:0] cnt_q, thr_q, cnt_inc;
   logic             zero_thr;

   assign cnt_inc  = cnt_q + CNT_W'(1);
   assign zero_thr = (thr_q == '0);
   // zero threshold: every event counts as a crossing
   assign hit_o    = inc_i && (zero_thr || (cnt_inc == thr_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_we_i) begin
         cnt_q <= cnt_wd_i;
      end else if (inc_i) begin
         cnt_q <= hit_o ? '0 : cnt_inc;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q <= CNT_W'(THR_INIT);
      end else if (thr_we_i) begin
         thr_q <= thr_wd_i;
      end
   end

   assign cnt_o = cnt_q;
   assign thr_o = thr_q;
endmodule

// File: rtl/mem_err_flags.sv
module mem_err_flags
   import mem_err_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sbe_hit_i,
   input  logic             mbe_i,
   input  logic             mse_i,
   input  logic             clr_we_i,
   input  logic [NFLAG-1:0] clr_mask_i,
   input  logic [NKIND-1:0] ien_i,
   output logic [NFLAG-1:0] flags_o,
   output logic             irq_o
);
   logic [NFLAG-1:0] flags_q, flags_d;
   logic [NKIND-1:0] irq_terms;

   always_comb begin
      flags_d = flags_q;
      if (clr_we_i) flags_d = flags_d & ~clr_mask_i;
      // hardware sets are applied after the clear so they win
      if (sbe_hit_i) begin
         flags_d[FLG_SBE] = 1'b1;
         if (flags_q[FLG_SBE]) flags_d[FLG_MULTI] = 1'b1;
      end
      if (mbe_i) begin
         flags_d[FLG_MBE] = 1'b1;
         if (flags_q[FLG_MBE]) flags_d[FLG_MULTI] = 1'b1;
      end
      if (mse_i) flags_d[FLG_MSE] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flags_d;
   end

   for (genvar k = 0; k < NKIND; k++) begin : g_irq
      assign irq_terms[k] = flags_q[k] & ien_i[k];
   end

   assign irq_o   = |irq_terms;
   assign flags_o = flags_q;
endmodule

// File: rtl/mem_err_capture.sv
module mem_err_capture
   import mem_err_pkg::*;
#(
   parameter int ERR_AW        = 32,
   parameter int DATA_W        = 64,
   parameter int ECC_W         = 8,
   parameter int BEAT_W        = 3,
   parameter int TSIZ_W        = 3,
   parameter int TSRC_W        = 5,
   parameter int TTYP_W        = 2,
   parameter int REG_DW        = 32,
   parameter bit CAPTURE_FIRST = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load_i,
   input  logic [ERR_AW-1:0]           addr_i,
   input  logic [DATA_W-1:0]           data_i,
   input  logic [ECC_W-1:0]            ecc_i,
   input  logic [BEAT_W-1:0]           beat_i,
   input  logic [TSIZ_W-1:0]           tsiz_i,
   input  logic [TSRC_W-1:0]           tsrc_i,
   input  logic [TTYP_W-1:0]           ttyp_i,
   input  logic [NCAP-1:0]             wsel_i,
   input  logic [REG_DW-1:0]           wdata_i,
   input  logic [REG_DW-1:0]           wmask_i,
   output logic [NCAP-1:0][REG_DW-1:0] cap_o
);
   localparam int IX_ADDR = 0;
   localparam int IX_DHI  = 1;
   localparam int IX_DLO  = 2;
   localparam int IX_ECC  = 3;
   localparam int IX_ATTR = 4;

   localparam logic [REG_DW-1:0] M_ATTR =
      REG_DW'(field_mask(1, AT_VLD)      | field_mask(BEAT_W, AT_BEAT) |
              field_mask(TSIZ_W, AT_TSIZ) | field_mask(TSRC_W, AT_TSRC) |
              field_mask(TTYP_W, AT_TTYP));

   localparam logic [NCAP-1:0][REG_DW-1:0] FMASK = {
      M_ATTR,
      REG_DW'(field_mask(ECC_W, 0)),
      {REG_DW{1'b1}},
      {REG_DW{1'b1}},
      REG_DW'(field_mask(ERR_AW, 0))
   };

   logic [NCAP-1:0][REG_DW-1:0] cap_q, ld_w;
   logic                        valid, load_en;
   logic [REG_DW-1:0]           attr_w;

   always_comb begin
      attr_w = '0;
      attr_w[AT_VLD]                = 1'b1;
      attr_w[AT_BEAT +: BEAT_W]     = beat_i;
      attr_w[AT_TSIZ +: TSIZ_W]     = tsiz_i;
      attr_w[AT_TSRC +: TSRC_W]     = tsrc_i;
      attr_w[AT_TTYP +: TTYP_W]     = ttyp_i;
   end

   assign ld_w[IX_ADDR] = REG_DW'(addr_i);
   assign ld_w[IX_DHI]  = data_i[DATA_W-1 -: REG_DW];
   assign ld_w[IX_DLO]  = data_i[REG_DW-1:0];
   assign ld_w[IX_ECC]  = REG_DW'(ecc_i);
   assign ld_w[IX_ATTR] = attr_w;

   assign valid = cap_q[IX_ATTR][AT_VLD];

   if (CAPTURE_FIRST) begin : g_first
      // hold the first error until software clears valid
      assign load_en = load_i && !valid;
   end else begin : g_last
      assign load_en = load_i;
   end

   for (genvar k = 0; k < NCAP; k++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cap_q[k] <= '0;
         end else if (wsel_i[k]) begin
            cap_q[k] <= ((cap_q[k] & ~wmask_i) | (wdata_i & wmask_i)) & FMASK[k];
         end else if (load_en) begin
            cap_q[k] <= ld_w[k];
         end
      end
   end

   assign cap_o = cap_q;
endmodule

// File: rtl/mem_err_mgr.sv
module mem_err_mgr
   import mem_err_pkg::*;
#(
   parameter int ERR_AW        = 32,
   parameter int DATA_W        = 64,
   parameter int ECC_W         = 8,
   parameter int CNT_W         = 8,
   parameter int BEAT_W        = 3,
   parameter int TSIZ_W        = 3,
   parameter int TSRC_W        = 5,
   parameter int TTYP_W        = 2,
   parameter int REG_AW        = 4,
   parameter int REG_DW        = 32,
   parameter int SBE_THR_INIT  = 255,
   parameter bit CAPTURE_FIRST = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  evt_valid,
   input  logic [1:0]            evt_type,
   input  logic [ERR_AW-1:0]     evt_addr,
   input  logic [DATA_W-1:0]     evt_data,
   input  logic [ECC_W-1:0]      evt_ecc,
   input  logic [BEAT_W-1:0]     evt_beat,
   input  logic [TSIZ_W-1:0]     evt_tsiz,
   input  logic [TSRC_W-1:0]     evt_tsrc,
   input  logic [TTYP_W-1:0]     evt_ttyp,
   input  logic                  reg_wr,
   input  logic [REG_AW-1:0]     reg_addr,
   input  logic [REG_DW-1:0]     reg_wdata,
   input  logic [REG_DW/8-1:0]   reg_wstrb,
   output logic [REG_DW-1:0]     reg_rdata,
   output logic                  irq
);
   localparam int NB = REG_DW / 8;

   // elaboration-time parameter checks
   if (REG_DW != 32) begin : g_bad_dw
      $error("mem_err_mgr: REG_DW must be 32");
   end
   if (DATA_W != 2 * REG_DW) begin : g_bad_data
      $error("mem_err_mgr: DATA_W must be two register words");
   end
   if (ERR_AW > REG_DW || ECC_W > REG_DW) begin : g_bad_fw
      $error("mem_err_mgr: address or check width exceeds a register word");
   end
   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
      $error("mem_err_mgr: CNT_W must fit one byte lane");
   end
   if (SBE_THR_INIT < 0 || SBE_THR_INIT >= (1 << CNT_W)) begin : g_bad_thr
      $error("mem_err_mgr: SBE_THR_INIT out of range");
   end
   if (BEAT_W > 4 || TSIZ_W > 8 || TSRC_W > 8 || TTYP_W > 8) begin : g_bad_attr
      $error("mem_err_mgr: attribute field too wide");
   end
   if ((1 << REG_AW) < NREG) begin : g_bad_aw
      $error("mem_err_mgr: REG_AW too small for the register map");
   end

   // write decode
   logic [REG_DW-1:0] wmask;
   logic [NREG-1:0]   wsel;

   for (genvar b = 0; b < NB; b++) begin : g_lane
      assign wmask[b*8 +: 8] = {8{reg_wstrb[b]}};
   end
   for (genvar r = 0; r < NREG; r++) begin : g_wsel
      assign wsel[r] = reg_wr && (reg_addr == REG_AW'(r));
   end

   // control registers
   logic [NKIND-1:0] dis_q, ien_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dis_q <= '0;
         ien_q <= '0;
      end else begin
         if (wsel[RA_DIS])
            dis_q <= (dis_q & ~wmask[NKIND-1:0]) | (reg_wdata[NKIND-1:0] & wmask[NKIND-1:0]);
         if (wsel[RA_IEN])
            ien_q <= (ien_q & ~wmask[NKIND-1:0]) | (reg_wdata[NKIND-1:0] & wmask[NKIND-1:0]);
      end
   end

   // event acceptance
   logic acc_sbe, acc_mbe, acc_mse, acc_any;

   assign acc_sbe = evt_valid && (evt_type == EV_SINGLE) && !dis_q[FLG_SBE];
   assign acc_mbe = evt_valid && (evt_type == EV_MULTI)  && !dis_q[FLG_MBE];
   assign acc_mse = evt_valid && (evt_type == EV_MSEL)   && !dis_q[FLG_MSE];
   assign acc_any = acc_sbe || acc_mbe || acc_mse;

   // single-bit counter and threshold
   logic [CNT_W-1:0] sbe_cnt, sbe_thr;
   logic             sbe_hit;

   mem_err_sbe_ctr #(
      .CNT_W    (CNT_W),
      .THR_INIT (SBE_THR_INIT)
   ) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc_i    (acc_sbe),
      .cnt_we_i (wsel[RA_SBE] && reg_wstrb[SBE_CNT_LSB/8]),
      .cnt_wd_i (reg_wdata[SBE_CNT_LSB +: CNT_W]),
      .thr_we_i (wsel[RA_SBE] && reg_wstrb[SBE_THR_LSB/8]),
      .thr_wd_i (reg_wdata[SBE_THR_LSB +: CNT_W]),
      .cnt_o    (sbe_cnt),
      .thr_o    (sbe_thr),
      .hit_o    (sbe_hit)
   );

   // detect flags and interrupt
   logic [NFLAG-1:0] det_flags;

   mem_err_flags u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .sbe_hit_i  (sbe_hit),
      .mbe_i      (acc_mbe),
      .mse_i      (acc_mse),
      .clr_we_i   (wsel[RA_STATUS]),
      .clr_mask_i (reg_wdata[NFLAG-1:0] & wmask[NFLAG-1:0]),
      .ien_i      (ien_q),
      .flags_o    (det_flags),
      .irq_o      (irq)
   );

   // capture
   logic [NCAP-1:0][REG_DW-1:0] cap_w;
   logic [REG_DW-1:0]           cap_addr_word;
   logic                        cap_valid;

   mem_err_capture #(
      .ERR_AW        (ERR_AW),
      .DATA_W        (DATA_W),
      .ECC_W         (ECC_W),
      .BEAT_W        (BEAT_W),
      .TSIZ_W        (TSIZ_W),
      .TSRC_W        (TSRC_W),
      .TTYP_W        (TTYP_W),
      .REG_DW        (REG_DW),
      .CAPTURE_FIRST (CAPTURE_FIRST)
   ) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (acc_any),
      .addr_i  (evt_addr),
      .data_i  (evt_data),
      .ecc_i   (evt_ecc),
      .beat_i  (evt_beat),
      .tsiz_i  (evt_tsiz),
      .tsrc_i  (evt_tsrc),
      .ttyp_i  (evt_ttyp),
      .wsel_i  (wsel[RA_CATTR:RA_CADDR]),
      .wdata_i (reg_wdata),
      .wmask_i (wmask),
      .cap_o   (cap_w)
   );

   assign cap_addr_word = cap_w[0];
   assign cap_valid     = cap_w[NCAP-1][AT_VLD];

   // read mux
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         REG_AW'(RA_STATUS): reg_rdata[NFLAG-1:0] = det_flags;
         REG_AW'(RA_DIS):    reg_rdata[NKIND-1:0] = dis_q;
         REG_AW'(RA_IEN):    reg_rdata[NKIND-1:0] = ien_q;
         REG_AW'(RA_SBE): begin
            reg_rdata[SBE_CNT_LSB +: CNT_W] = sbe_cnt;
            reg_rdata[SBE_THR_LSB +: CNT_W] = sbe_thr;
         end
         REG_AW'(RA_CADDR):  reg_rdata = cap_w[0];
         REG_AW'(RA_CDHI):   reg_rdata = cap_w[1];
         REG_AW'(RA_CDLO):   reg_rdata = cap_w[2];
         REG_AW'(RA_CECC):   reg_rdata = cap_w[3];
         REG_AW'(RA_CATTR):  reg_rdata = cap_w[4];
         default:            reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/mem_err_mgr_chk.sv
module mem_err_mgr_chk #(
   parameter int CNT_W         = 8,
   parameter int REG_DW        = 32,
   parameter bit CAPTURE_FIRST = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              evt_valid,
   input logic [1:0]        evt_type,
   input logic              reg_wr,
   input logic              irq,
   input logic [3:0]        flags,
   input logic [2:0]        dis,
   input logic [CNT_W-1:0]  sbe_cnt,
   input logic              cap_valid,
   input logic [REG_DW-1:0] cap_addr
);
   // R7: flags only fall through a register write
   assert_flags_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> ((flags & $past(flags)) == $past(flags)));

   // R8: disabled multi-bit events do not raise the flag
   assert_mbe_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_type == 2'd1 && dis[1] && !flags[1]) |=> !flags[1]);

   // R8: disabled memory-select events do not raise the flag
   assert_mse_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_type == 2'd2 && dis[2] && !flags[2]) |=> !flags[2]);

   // R6: memory-select events never raise the repeat flag
   assert_mse_no_repeat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_type == 2'd2 && !flags[3]) |=> !flags[3]);

   // R3: counter moves only on an event or a write
   assert_cnt_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_valid && !reg_wr) |=> $stable(sbe_cnt));

   // R9: interrupt level holds without stimulus
   assert_irq_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_valid && !reg_wr) |=> $stable(irq));

   if (CAPTURE_FIRST) begin : g_hold
      // R10: a valid capture is frozen except by software
      assert_cap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (cap_valid && !reg_wr) |=> ($stable(cap_addr) && cap_valid));
   end
endmodule

bind mem_err_mgr mem_err_mgr_chk #(
   .CNT_W         (CNT_W),
   .REG_DW        (REG_DW),
   .CAPTURE_FIRST (CAPTURE_FIRST)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_valid (evt_valid),
   .evt_type  (evt_type),
   .reg_wr    (reg_wr),
   .irq       (irq),
   .flags     (det_flags),
   .dis       (dis_q),
   .sbe_cnt   (sbe_cnt),
   .cap_valid (cap_valid),
   .cap_addr  (cap_addr_word)
);

// File: tb/mem_err_mgr_test.sv
`timescale 1ns/1ps
module mem_err_mgr_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_valid = 1'b0;
   logic [1:0]  evt_type = 2'd3;
   logic [31:0] evt_addr = '0;
   logic [63:0] evt_data = '0;
   logic [7:0]  evt_ecc = '0;
   logic [2:0]  evt_beat = '0;
   logic [2:0]  evt_tsiz = '0;
   logic [4:0]  evt_tsrc = '0;
   logic [1:0]  evt_ttyp = '0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [3:0]  reg_wstrb = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   mem_err_mgr uut (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_type(evt_type),
      .evt_addr(evt_addr), .evt_data(evt_data), .evt_ecc(evt_ecc),
      .evt_beat(evt_beat), .evt_tsiz(evt_tsiz), .evt_tsrc(evt_tsrc),
      .evt_ttyp(evt_ttyp), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_wstrb(reg_wstrb), .reg_rdata(reg_rdata),
      .irq(irq)
   );

   localparam int A_ST = 0, A_DIS = 1, A_IEN = 2, A_SBE = 3;
   localparam int A_CA = 4, A_CH = 5, A_CL = 6, A_CE = 7, A_CT = 8;

   // {kind, expected status, expected counter} with threshold 3, all enables on
   localparam logic [13:0] VEC [10] = '{
      {2'd0, 4'h0, 8'd1},
      {2'd0, 4'h0, 8'd2},
      {2'd0, 4'h1, 8'd0},
      {2'd2, 4'h5, 8'd0},
      {2'd0, 4'h5, 8'd1},
      {2'd0, 4'h5, 8'd2},
      {2'd0, 4'hD, 8'd0},
      {2'd1, 4'hF, 8'd0},
      {2'd1, 4'hF, 8'd0},
      {2'd3, 4'hF, 8'd0}
   };

   function automatic logic [31:0] x_addr(input int i);
      return 32'h0000_1000 + 32'(i * 8);
   endfunction
   function automatic logic [63:0] x_data(input int i);
      return {32'hA5A5_0000 + 32'(i), 32'h5A5A_0000 + 32'(i)};
   endfunction
   function automatic logic [31:0] x_attr(input int i);
      return 32'h1 | (32'(i % 8) << 4) | (32'd2 << 8) | (32'((i + 3) % 32) << 16) | (32'd1 << 24);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic rdchk(input int a, input logic [31:0] exp, input string tag);
      reg_addr = 4'(a);
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic wr(input int a, input logic [31:0] d, input logic [3:0] s);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d; reg_wstrb = s;
      @(negedge clk);
      reg_wr = 1'b0; reg_wstrb = '0;
   endtask

   task automatic set_evt(input logic [1:0] t, input int i);
      evt_valid = 1'b1; evt_type = t;
      evt_addr = x_addr(i); evt_data = x_data(i); evt_ecc = 8'h30 + 8'(i);
      evt_beat = 3'(i % 8); evt_tsiz = 3'd2; evt_tsrc = 5'((i + 3) % 32); evt_ttyp = 2'd1;
   endtask

   task automatic ev(input logic [1:0] t, input int i);
      @(negedge clk);
      set_evt(t, i);
      @(negedge clk);
      evt_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rdchk(A_ST, 32'h0, "R1 status");
      rdchk(A_DIS, 32'h0, "R1 disable");
      rdchk(A_IEN, 32'h0, "R1 enable");
      rdchk(A_SBE, 32'h00FF_0000, "R1 sbe word");
      rdchk(A_CA, 32'h0, "R1 cap addr");
      rdchk(A_CT, 32'h0, "R1 cap attr");
      rdchk(12, 32'h0, "R2 unmapped");
      chk("R1 irq", 32'(irq), 32'h0);

      // R2 byte-lane field writes
      wr(A_SBE, 32'h0005_0007, 4'b0001);
      rdchk(A_SBE, 32'h00FF_0007, "R2 counter-only write");
      wr(A_SBE, 32'h0003_00AA, 4'b0100);
      rdchk(A_SBE, 32'h0003_0007, "R2 threshold-only write");
      wr(A_SBE, 32'h0, 4'b0001);
      wr(A_IEN, 32'h7, 4'hF);
      rdchk(A_IEN, 32'h7, "R2 enable readback");

      // R3 R4 R6 R9 event table
      for (int k = 0; k < 10; k++) begin
         ev(VEC[k][13:12], k);
         rdchk(A_ST, 32'(VEC[k][11:8]), $sformatf("R3/R4/R6 status vec %0d", k));
         rdchk(A_SBE, 32'h0003_0000 | 32'(VEC[k][7:0]), $sformatf("R3 counter vec %0d", k));
         chk($sformatf("R9 irq vec %0d", k), 32'(irq), 32'(|VEC[k][10:8]));
      end

      // R10 first event held
      rdchk(A_CA, x_addr(0), "R10 cap addr first");
      rdchk(A_CH, x_data(0)[63:32], "R10 cap data hi");
      rdchk(A_CL, x_data(0)[31:0], "R10 cap data lo");
      rdchk(A_CE, 32'h30, "R10 cap ecc");
      rdchk(A_CT, x_attr(0), "R10 cap attr");

      // R7 write-one-to-clear
      wr(A_ST, 32'h2, 4'hF);
      rdchk(A_ST, 32'hD, "R7 partial clear");
      wr(A_ST, 32'hF, 4'hF);
      rdchk(A_ST, 32'h0, "R7 full clear");
      chk("R9 irq after clear", 32'(irq), 32'h0);
      // R7 set beats clear in the same cycle
      @(negedge clk);
      set_evt(2'd1, 20);
      reg_wr = 1'b1; reg_addr = 4'(A_ST); reg_wdata = 32'h2; reg_wstrb = 4'hF;
      @(negedge clk);
      evt_valid = 1'b0; reg_wr = 1'b0; reg_wstrb = '0;
      rdchk(A_ST, 32'h2, "R7 set wins over clear");
      rdchk(A_CA, x_addr(0), "R10 cap addr held");

      // R6 repeat multi-bit, memory-select never repeats
      ev(2'd1, 21);
      rdchk(A_ST, 32'hA, "R6 multi-bit repeat");
      wr(A_ST, 32'hF, 4'hF);
      ev(2'd2, 22);
      ev(2'd2, 23);
      rdchk(A_ST, 32'h4, "R6 memory-select no repeat");
      wr(A_ST, 32'hF, 4'hF);

      // R5 zero threshold
      wr(A_SBE, 32'h0, 4'b0100);
      ev(2'd0, 24);
      rdchk(A_ST, 32'h1, "R5 zero threshold first");
      rdchk(A_SBE, 32'h0, "R5 counter stays zero");
      ev(2'd0, 25);
      rdchk(A_ST, 32'h9, "R5 zero threshold repeat");
      wr(A_ST, 32'hF, 4'hF);

      // R11 writing zero clears, R10 re-arm
      wr(A_CT, 32'h0, 4'hF);
      rdchk(A_CT, 32'h0, "R11 attr cleared");
      wr(A_CA, 32'h0, 4'hF);
      rdchk(A_CA, 32'h0, "R11 addr cleared");
      wr(A_CH, 32'h0, 4'hF);
      rdchk(A_CH, 32'h0, "R11 data hi cleared");
      wr(A_CE, 32'h0, 4'hF);
      rdchk(A_CE, 32'h0, "R11 ecc cleared");
      ev(2'd2, 7);
      rdchk(A_CA, x_addr(7), "R10 re-armed addr");
      rdchk(A_CL, x_data(7)[31:0], "R10 re-armed data lo");
      rdchk(A_CE, 32'h37, "R10 re-armed ecc");
      rdchk(A_CT, x_attr(7), "R10 re-armed attr");
      wr(A_ST, 32'hF, 4'hF);

      // R8 disabled kinds ignored
      wr(A_CT, 32'h0, 4'hF);
      wr(A_DIS, 32'h7, 4'hF);
      rdchk(A_DIS, 32'h7, "R8 disable readback");
      ev(2'd0, 30);
      ev(2'd1, 31);
      ev(2'd2, 32);
      rdchk(A_ST, 32'h0, "R8 no flags");
      rdchk(A_SBE, 32'h0, "R8 no count");
      rdchk(A_CT, 32'h0, "R8 no capture");
      chk("R8 no irq", 32'(irq), 32'h0);
      wr(A_DIS, 32'h0, 4'hF);

      // R9 enable masking and hold
      wr(A_IEN, 32'h2, 4'hF);
      ev(2'd0, 40);
      rdchk(A_ST, 32'h1, "R9 single-bit flag set");
      chk("R9 masked flag no irq", 32'(irq), 32'h0);
      ev(2'd1, 41);
      chk("R9 enabled flag irq", 32'(irq), 32'h1);
      repeat (3) @(negedge clk);
      chk("R9 irq held", 32'(irq), 32'h1);
      wr(A_ST, 32'h2, 4'hF);
      chk("R9 irq drops with flag", 32'(irq), 32'h0);
      wr(A_IEN, 32'h1, 4'hF);
      chk("R9 irq follows enable", 32'(irq), 32'h1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule